// File: doc/BRIEF.md
# Trinary Pulse-Width Serial Encoder

This block turns a word of nine three-level digits into a serial pulse-width stream for a remote-control link. Every digit is given as a two-bit code for low, high or open. On the line, each digit occupies one data period. That period is split into two halves, and each half carries one pulse. The pulse is short or long, and the pair of widths tells the receiver which of the three levels was sent.

An active-low send request starts an encoding sequence. A sequence sends the word, stays silent for three data periods, and then sends the word again. If the request is still low when the second copy ends, the line stays silent for another three periods and a fresh sequence follows. If the request is high at that point, the block drops back to idle with the line low. A request that is low for a single clock is enough to produce one full two-word sequence. A single clock stands in for the transmit oscillator.

The digit inputs are captured on the clock edge that begins each word. Each copy of the word therefore reflects the inputs at its own start, and changes in the middle of a word have no effect.

Top module: `tri_pw_encoder`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) forces `dout_o` low from that edge on and returns the block to idle, including in the middle of a sequence.
- R2: A digit coded 2'b00 (low) is sent as a short pulse in each of its two halves. With the default timing, each half is 4 clocks long and is high for its first clock only.
- R3: A digit coded 2'b01 (high) is sent as a long pulse in each of its two halves. Each half is high for its first 3 clocks and low for its last clock.
- R4: A digit coded 2'b10 (open) is sent as a long pulse in its first half and a short pulse in its second half. The unused code 2'b11 is sent the same way as open.
- R5: Each digit takes one data period of 8 clocks. Digits go out in order from digit 1 (`digits_i[1:0]`) to digit 9 (`digits_i[17:16]`), so one word lasts 72 clocks.
- R6: Between the first and second word of a sequence, `dout_o` stays low for 3 data periods (24 clocks).
- R7: A clock edge in idle that sees `send_n` low starts a sequence. `dout_o` rises at the next edge, with the first pulse of digit 1. `send_n` has no effect while a word or gap is in progress.
- R8: When `send_n` is low for only one clock, exactly one two-word sequence is sent, after which `dout_o` stays low.
- R9: If `send_n` is low at the last clock of the second word, `dout_o` stays low for 24 clocks and a new sequence then begins.
- R10: The digit inputs are captured on the edge that starts each word, and changes in the middle of a word do not alter that word. The second word of a sequence uses the inputs present when it starts.
- R11: While idle with `send_n` high, `dout_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick of the transmit time base |
| rst_n | input | 1 | Synchronous reset, active low |
| send_n | input | 1 | Send request, active low |
| digits_i | input | 18 | Nine two-bit digit codes, digit 1 in the lowest bits |
| dout_o | output | 1 | Serial pulse-width output |

## Verification
The assertions are checked on every cycle. They cover these properties:
- the line is low after reset, in the gaps and in idle;
- every half-period begins with a rising pulse and ends low;
- the gap counter stays in range;
- a word, once started, runs to its end.

Other behaviour depends on whole sequences, and only the bench's scenarios can show it:
- the pulse widths for each digit code, and the order in which the digits go out;
- the capture of the inputs at each word start;
- the ending after a one-clock request, and back-to-back repetition;
- a reset in the middle of a word.

The bench's behavioural model predicts every output bit, and the bench compares it with the design on each clock.

// File: rtl/tpw_pkg.sv
// Shared types for the trinary pulse-width encoder.
// Assumes two-bit digit codes: 00 low, 01 high, 10 or 11 open.
package tpw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_t;

    localparam logic [1:0] CODE_LOW  = 2'b00;
    localparam logic [1:0] CODE_HIGH = 2'b01;

    // Width class of the first pulse: long for every code except low.
    function automatic logic first_half_long(input logic [1:0] code);
        return code != CODE_LOW;
    endfunction

    // Width class of the second pulse: long only for high.
    function automatic logic second_half_long(input logic [1:0] code);
        return code == CODE_HIGH;
    endfunction

endpackage

// File: rtl/tpw_sequencer.sv
// Sequencer: walks each word through its digits, halves and ticks, then
// through the silent gap, and decides whether to go idle or repeat.
// Assumes start_n is already synchronous to clk.
module tpw_sequencer
    import tpw_pkg::*;
#(
    parameter int NUM_DIGITS  = 9,
    parameter int HALF_CLKS   = 4,
    parameter int GAP_PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic load_o,
    output logic active_o,
    output logic [((NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1)-1:0] digit_o,
    output logic half_o,
    output logic [((HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1)-1:0] tick_o
);

    localparam int DIG_W    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int TICK_W   = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int GAP_CLKS = GAP_PERIODS * 2 * HALF_CLKS;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);

    seq_state_t        state_q;
    logic              second_q;
    logic [DIG_W-1:0]  digit_q;
    logic              half_q;
    logic [TICK_W-1:0] tick_q;
    logic [GAP_W-1:0]  gap_q;
    logic              tick_last;
    logic              word_end;
    logic              gap_end;

    // Decode the end of a half, of a word and of a gap.
    always_comb begin
        tick_last = (tick_q == TICK_W'(HALF_CLKS - 1));
        word_end  = (state_q == SEQ_SEND) && half_q && tick_last &&
                    (digit_q == DIG_W'(NUM_DIGITS - 1));
        gap_end   = (state_q == SEQ_GAP) && (gap_q == GAP_W'(GAP_CLKS - 1));
        load_o    = ((state_q == SEQ_IDLE) && !start_n) || gap_end;
    end

    // Advance state and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            second_q <= 1'b0;
            digit_q  <= '0;
            half_q   <= 1'b0;
            tick_q   <= '0;
            gap_q    <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (!start_n) begin
                        state_q  <= SEQ_SEND;
                        second_q <= 1'b0;
                        digit_q  <= '0;
                        half_q   <= 1'b0;
                        tick_q   <= '0;
                    end
                end
                SEQ_SEND: begin
                    if (tick_last) begin
                        tick_q <= '0;
                        half_q <= ~half_q;
                        if (half_q) begin
                            digit_q <= digit_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                    if (word_end) begin
                        digit_q <= '0;
                        gap_q   <= '0;
                        if (!second_q) begin
                            state_q  <= SEQ_GAP;
                            second_q <= 1'b1;
                        end else if (!start_n) begin
                            state_q  <= SEQ_GAP;
                            second_q <= 1'b0;
                        end else begin
                            state_q  <= SEQ_IDLE;
                            second_q <= 1'b0;
                        end
                    end
                end
                SEQ_GAP: begin
                    if (gap_end) begin
                        state_q <= SEQ_SEND;
                        gap_q   <= '0;
                        digit_q <= '0;
                        half_q  <= 1'b0;
                        tick_q  <= '0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign active_o = (state_q == SEQ_SEND);
    assign digit_o  = digit_q;
    assign half_o   = half_q;
    assign tick_o   = tick_q;

    // R6: the gap counter never passes the gap length.
    assert_gap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GAP) |-> (gap_q < GAP_W'(GAP_CLKS)));

    // R7: a capture strobe is followed by digit 1, first half, first tick.
    assert_start_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == SEQ_SEND && digit_q == '0 && !half_q && tick_q == '0));

    // R5: a word in progress cannot be cut short by the request input.
    assert_word_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SEND && !word_end) |=> (state_q == SEQ_SEND));

    // R6: the end of a gap always leads straight into a word.
    assert_gap_to_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gap_end |=> active_o);

endmodule

// File: rtl/tpw_digit_store.sv
// Digit store: captures the whole digit word on a load strobe and presents
// the code of the digit picked by the sequencer.
// Assumes sel_i stays below NUM_DIGITS while a word is being sent.
module tpw_digit_store #(
    parameter int NUM_DIGITS = 9,
    parameter int DIG_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [2*NUM_DIGITS-1:0]   digits_i,
    input  logic [DIG_W-1:0]          sel_i,
    output logic [1:0]                code_o
);

    logic [NUM_DIGITS-1:0][1:0] slot_q;

    // One capture register per digit slot.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= 2'b00;
            end else if (load_i) begin
                slot_q[g] <= digits_i[2*g +: 2];
            end
        end
    end

    // Pick the code of the digit now on the line.
    always_comb begin
        code_o = 2'b00;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (sel_i == DIG_W'(i)) begin
                code_o = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/tpw_pulse_shaper.sv
// Pulse shaper: registers the line output, high from the start of each half
// for the short or long width chosen by the current digit code.
// Assumes SHORT_CLKS < LONG_CLKS < HALF_CLKS.
module tpw_pulse_shaper
    import tpw_pkg::*;
#(
    parameter int HALF_CLKS  = 4,
    parameter int SHORT_CLKS = 1,
    parameter int LONG_CLKS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic half_i,
    input  logic [((HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1)-1:0] tick_i,
    input  logic [1:0] code_i,
    output logic dout_o
);

    localparam int TICK_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic              use_long;
    logic [TICK_W:0]   width;
    logic              dout_q;

    // Choose the width of the pulse in the current half.
    always_comb begin
        use_long = half_i ? second_half_long(code_i) : first_half_long(code_i);
        width    = use_long ? (TICK_W+1)'(LONG_CLKS) : (TICK_W+1)'(SHORT_CLKS);
    end

    // Register the line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else begin
            dout_q <= active_i && ({1'b0, tick_i} < width);
        end
    end

    assign dout_o = dout_q;

    // R1: reset drives the line low by the next cycle.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !dout_o);

    // R6: no pulse while no word is being sent.
    assert_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !dout_o);

    // R2: every half ends low, so pulses stay separate.
    assert_half_ends_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && tick_i == TICK_W'(HALF_CLKS - 1)) |=> !dout_o);

    // R4: every half starts with a rising pulse.
    assert_half_starts_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && tick_i == '0) |=> dout_o);

endmodule

// File: rtl/tri_pw_encoder.sv
// Trinary pulse-width serial encoder top: links the sequencer, the digit
// store and the pulse shaper. Output lags the sequencer by one register.
// Assumes send_n is synchronous to clk.
module tri_pw_encoder #(
    parameter int NUM_DIGITS  = 9,
    parameter int HALF_CLKS   = 4,
    parameter int SHORT_CLKS  = 1,
    parameter int LONG_CLKS   = 3,
    parameter int GAP_PERIODS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    send_n,
    input  logic [2*NUM_DIGITS-1:0] digits_i,
    output logic                    dout_o
);

    localparam int DIG_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int TICK_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic              load;
    logic              active;
    logic [DIG_W-1:0]  digit;
    logic              half;
    logic [TICK_W-1:0] tick;
    logic [1:0]        code;

    tpw_sequencer #(
        .NUM_DIGITS (NUM_DIGITS),
        .HALF_CLKS  (HALF_CLKS),
        .GAP_PERIODS(GAP_PERIODS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_n (send_n),
        .load_o  (load),
        .active_o(active),
        .digit_o (digit),
        .half_o  (half),
        .tick_o  (tick)
    );

    tpw_digit_store #(
        .NUM_DIGITS(NUM_DIGITS),
        .DIG_W     (DIG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .digits_i(digits_i),
        .sel_i   (digit),
        .code_o  (code)
    );

    tpw_pulse_shaper #(
        .HALF_CLKS (HALF_CLKS),
        .SHORT_CLKS(SHORT_CLKS),
        .LONG_CLKS (LONG_CLKS)
    ) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .half_i  (half),
        .tick_i  (tick),
        .code_i  (code),
        .dout_o  (dout_o)
    );

endmodule

// File: tb/tri_pw_encoder_test.sv
`timescale 1ns/1ps
module tri_pw_encoder_test;

    localparam int WORD_CLKS = 72;
    localparam int GAP_CLKS  = 24;
    localparam int W2_START  = WORD_CLKS + GAP_CLKS;      // 96
    localparam int W2_LAST   = W2_START + WORD_CLKS - 1;  // 167
    localparam int TAIL_LAST = W2_LAST + GAP_CLKS;        // 191

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        send_n = 1'b1;
    logic [17:0] digits = '0;
    logic        dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;

    int          ph = -1;
    logic [17:0] snap = '0;
    bit          exp_q = 1'b0;
    string       tag_q = "R1";

    tri_pw_encoder uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .send_n  (send_n),
        .digits_i(digits),
        .dout_o  (dout)
    );

    always #10 clk = ~clk;

    // Expected line level for a sequence position and captured word.
    function automatic bit model_bit(int p, logic [17:0] w);
        int q;
        int d;
        int t;
        logic [1:0] c;
        bit lng;
        if (p < 0) return 1'b0;
        if (p < WORD_CLKS) q = p;
        else if (p >= W2_START && p <= W2_LAST) q = p - W2_START;
        else return 1'b0;
        d = q / 8;
        t = q % 8;
        c = w[2*d +: 2];
        lng = (t < 4) ? (c != 2'b00) : (c == 2'b01);
        return (t % 4) < (lng ? 3 : 1);
    endfunction

    function automatic string model_tag(int p, logic [17:0] w);
        int q;
        logic [1:0] c;
        if (p < 0) return "R11";
        if (p >= WORD_CLKS && p < W2_START) return "R6";
        if (p > W2_LAST) return "R9";
        q = (p < WORD_CLKS) ? p : p - W2_START;
        c = w[2*(q/8) +: 2];
        if (c == 2'b00) return "R2 R5 R7 R10";
        if (c == 2'b01) return "R3 R5 R7 R10";
        return "R4 R5 R7 R10";
    endfunction

    // Behavioural reference model, stepped on every edge.
    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            ph    = -1;
            exp_q = 1'b0;
            tag_q = "R1";
        end else begin
            exp_q = model_bit(ph, snap);
            tag_q = model_tag(ph, snap);
            if (ph == -1) begin
                if (!send_n) begin ph = 0; snap = digits; end
            end else if (ph == W2_START - 1) begin
                ph = W2_START; snap = digits;
            end else if (ph == W2_LAST) begin
                ph = send_n ? -1 : W2_LAST + 1;
            end else if (ph == TAIL_LAST) begin
                ph = 0; snap = digits;
            end else begin
                ph++;
            end
        end
    end

    task automatic check(input bit cond, input string tag, input bit act, input bit expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: dout=%0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) check(dout === exp_q, tag_q, dout, exp_q);
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        check(dout === 1'b0, "R1 reset", dout, 1'b0);
        rst_n = 1'b1;
        cycles(10);
        check(dout === 1'b0, "R11 idle", dout, 1'b0);

        // One-clock request with a mix of codes, including 11.
        digits = {2'b11, 2'b10, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10};
        send_n = 1'b0;
        cycles(1);
        send_n = 1'b1;
        check(dout === 1'b0, "R7 no pulse yet", dout, 1'b0);
        cycles(1);
        check(dout === 1'b1, "R7 first rise", dout, 1'b1);
        cycles(200);
        check(dout === 1'b0, "R8 idle after one sequence", dout, 1'b0);

        // Inputs changed mid word 1 and in the gap.
        digits = 18'h00000;
        send_n = 1'b0;
        cycles(1);
        send_n = 1'b1;
        cycles(30);
        digits = {9{2'b01}};
        cycles(55);
        digits = {2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10};
        cycles(120);
        check(dout === 1'b0, "R10 sequence done", dout, 1'b0);

        // Continuous request with request toggling mid-sequence.
        digits = {2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b01};
        send_n = 1'b0;
        cycles(150);
        send_n = 1'b1;
        cycles(5);
        send_n = 1'b0;
        cycles(200);
        digits = {9{2'b10}};
        cycles(260);
        send_n = 1'b1;
        cycles(400);
        check(dout === 1'b0, "R9 idle after release", dout, 1'b0);

        // Reset in the middle of a word.
        send_n = 1'b0;
        cycles(1);
        send_n = 1'b1;
        cycles(20);
        rst_n = 1'b0;
        cycles(1);
        check(dout === 1'b0, "R1 mid-word reset", dout, 1'b0);
        rst_n = 1'b1;
        cycles(40);
        check(dout === 1'b0, "R1 stays idle", dout, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule